// File: doc/BRIEF.md
# Paravirtual Device Register Front End

This block is the register face of a legacy paravirtual I/O device. A host bus reaches it through a small window with byte, halfword and word accesses. The common register area at the bottom of the window holds several things: a feature mask offered by the device, and the mask the guest accepts; a queue selector; per-queue page numbers, ring sizes and interrupt vectors; a device status byte; and an interrupt status byte that clears when it is read. When message-signalled interrupts are enabled, two more vector registers appear and push the device-specific area up by four bytes.

Any access at or above the start of the device-specific area goes straight out on a config port, with its offset taken relative to that start. The block also produces several outputs: a one-cycle queue-notify pulse carrying the written queue index, a one-cycle device-reset pulse, and a vector query to an external vector table, which answers in the same cycle. A legacy interrupt line follows the interrupt status while message-signalled interrupts are off.

Every read returns its data one cycle after the request, on `rsp_rdata` with `rsp_valid`. Byte offsets used by the bus: 0 device features (read-only), 4 guest features, 8 queue page number, 12 queue size (read-only), 14 queue select, 16 queue notify (write-only), 18 device status, 19 interrupt status (read-only). With message-signalled interrupts on, 20 is the config-change vector and 22 is the selected queue's vector.

Top module: `pv_regif`

## Requirements
- R1: After `rst_n` is released, these read 0: guest features, queue select, status, interrupt status and every queue page number. Every vector reads 0xFFFF and `irq_line` is low.
- R2: A read at offset 0 returns `dev_features` with bits 24, 28 and 30 forced to 1.
- R3: A write at offset 4 stores the written value. If bit 30 of the written value is 1, `dev_fallback` is stored in its place.
- R4: A non-zero write at offset 8 stores a page number for the selected queue. A read at offset 8 returns the page number of the currently selected queue.
- R5: Two writes reset the device: a write of 0 at offset 8, and a write at offset 18 whose low byte is 0. On that clock edge, guest features, status, interrupt status, queue select and all page numbers are cleared and all vectors are set to 0xFFFF. `dev_reset` is high for exactly the next cycle.
- R6: A write at offset 14 changes the selection only if its low 16 bits are below NQ. Otherwise the selection is kept.
- R7: A read at offset 12 returns the selected queue's size from the parameter `QSIZE_VEC` (16 bits per queue, queue 0 in the low bits).
- R8: Each cycle, `isr_set` is ORed into the interrupt status. A read at offset 19 returns the old value, and the register is then loaded with that cycle's `isr_set` only.
- R9: `irq_line` equals bit 0 of the interrupt status while `msix_en` is 0, and is 0 while `msix_en` is 1.
- R10: A write at offset 16 raises `notify_valid` for one cycle, with `notify_queue` set to the written low 16 bits.
- R11: With `msix_en` set, a write at offset 20 or 22 raises `vec_query_valid` with `vec_query_num` equal to the written value. The config-change vector (20) or the selected queue's vector (22) stores that value if `vec_accept` is 1, and 0xFFFF otherwise.
- R12: Accesses at or above offset 20 (or 24 when `msix_en` is 1) drive `cfg_valid` in the same cycle with `cfg_offset` = address minus that start. A read of that region returns `cfg_rdata`.
- R13: A read gets `rsp_valid` and its data exactly one cycle later. Reads at undefined offsets in the common area (including 16 and 21) return 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size, passed to the config port |
| req_addr | input | ADDR_W | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| dev_features | input | 32 | Device feature bits |
| dev_fallback | input | 32 | Feature set stored when the guest flags a bad negotiation |
| isr_set | input | 8 | Interrupt status bits to set |
| msix_en | input | 1 | Message-signalled interrupts enabled |
| vec_query_valid | output | 1 | Vector validation request |
| vec_query_num | output | 16 | Vector being validated |
| vec_accept | input | 1 | Vector table accepts the vector (same cycle) |
| cfg_valid | output | 1 | Access to the device-specific area |
| cfg_write | output | 1 | Config access is a write |
| cfg_size | output | 2 | Config access size |
| cfg_offset | output | ADDR_W | Offset within the device-specific area |
| cfg_wdata | output | 32 | Config write data |
| cfg_rdata | input | 32 | Config read data (same cycle) |
| irq_line | output | 1 | Legacy interrupt level |
| notify_valid | output | 1 | Queue notify pulse |
| notify_queue | output | 16 | Notified queue index |
| dev_reset | output | 1 | Device reset pulse |

## Verification
The bench targets the registers with side effects. A design that cleared the interrupt status before returning it would read back 0. One that let a set arriving in the read cycle be lost, or kept the old bits, would hold `irq_line` at the wrong level. The bench writes the selector with NQ and with 0xFFFF. A design that truncated those values would wrap onto queue 0 or 15 and then return that queue's page number. Writes of zero to the page or status register must clear all queues' state and vectors. A partial clear would leave an old page number or vector readable afterwards. The bench moves the config start by toggling `msix_en`, and uses rejected vectors that must read back as 0xFFFF. A one-off base calculation shows up as a wrong `cfg_offset` or as all-ones data where config data was due.

// File: rtl/pv_regif.sv
module pv_regif #(
  parameter int NQ = 16,
  parameter int ADDR_W = 8,
  parameter logic [NQ*16-1:0] QSIZE_VEC = {NQ{16'd256}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [31:0]       dev_features,
  input  logic [31:0]       dev_fallback,
  input  logic [7:0]        isr_set,
  input  logic              msix_en,
  output logic              vec_query_valid,
  output logic [15:0]       vec_query_num,
  input  logic              vec_accept,
  output logic              cfg_valid,
  output logic              cfg_write,
  output logic [1:0]        cfg_size,
  output logic [ADDR_W-1:0] cfg_offset,
  output logic [31:0]       cfg_wdata,
  input  logic [31:0]       cfg_rdata,
  output logic              irq_line,
  output logic              notify_valid,
  output logic [15:0]       notify_queue,
  output logic              dev_reset
);
  localparam int SW = (NQ > 1) ? $clog2(NQ) : 1;
  localparam logic [31:0] ALWAYS_ON = (32'd1 << 24) | (32'd1 << 28) | (32'd1 << 30);
  localparam int BAD_BIT = 30;
  localparam logic [15:0] NO_VEC = 16'hFFFF;

  logic [31:0]   gfeat;
  logic [SW-1:0] qsel;
  logic [7:0]    status;
  logic [7:0]    isr;
  logic [15:0]   cvec;
  logic [31:0]   pfn  [NQ];
  logic [15:0]   qvec [NQ];
  logic [31:0]   rdata_c;

  wire [ADDR_W-1:0] base = msix_en ? ADDR_W'(24) : ADDR_W'(20);
  wire in_cfg = req_addr >= base;
  wire wr = req_valid && req_write && !in_cfg;
  wire rd = req_valid && !req_write && !in_cfg;

  wire at_gf  = req_addr == ADDR_W'(4);
  wire at_pfn = req_addr == ADDR_W'(8);
  wire at_sel = req_addr == ADDR_W'(14);
  wire at_nt  = req_addr == ADDR_W'(16);
  wire at_st  = req_addr == ADDR_W'(18);
  wire at_isr = req_addr == ADDR_W'(19);
  wire at_cv  = req_addr == ADDR_W'(20);
  wire at_qv  = req_addr == ADDR_W'(22);

  wire clr = wr && ((at_pfn && req_wdata == 32'd0) || (at_st && req_wdata[7:0] == 8'd0));
  wire sel_ok = {16'd0, req_wdata[15:0]} < 32'(NQ);
  wire [15:0] vec_new = vec_accept ? req_wdata[15:0] : NO_VEC;

  assign cfg_valid  = req_valid && in_cfg;
  assign cfg_write  = req_write;
  assign cfg_size   = req_size;
  assign cfg_offset = req_addr - base;
  assign cfg_wdata  = req_wdata;

  assign vec_query_valid = wr && msix_en && (at_cv || at_qv);
  assign vec_query_num   = req_wdata[15:0];
  assign irq_line        = !msix_en && isr[0];

  always_comb begin
    rdata_c = '1;
    case (req_addr)
      ADDR_W'(0):  rdata_c = dev_features | ALWAYS_ON;
      ADDR_W'(4):  rdata_c = gfeat;
      ADDR_W'(8):  rdata_c = pfn[qsel];
      ADDR_W'(12): rdata_c = {16'd0, QSIZE_VEC[qsel*16 +: 16]};
      ADDR_W'(14): rdata_c = 32'(qsel);
      ADDR_W'(18): rdata_c = {24'd0, status};
      ADDR_W'(19): rdata_c = {24'd0, isr};
      ADDR_W'(20): rdata_c = {16'd0, cvec};
      ADDR_W'(22): rdata_c = {16'd0, qvec[qsel]};
      default:     rdata_c = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gfeat <= '0;
      qsel <= '0;
      status <= '0;
      isr <= '0;
      cvec <= NO_VEC;
      for (int i = 0; i < NQ; i++) begin
        pfn[i] <= '0;
        qvec[i] <= NO_VEC;
      end
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      notify_valid <= 1'b0;
      notify_queue <= '0;
      dev_reset <= 1'b0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= in_cfg ? cfg_rdata : rdata_c;
      notify_valid <= wr && at_nt;
      if (wr && at_nt) notify_queue <= req_wdata[15:0];
      dev_reset <= clr;
      if (clr) begin
        gfeat <= '0;
        qsel <= '0;
        status <= '0;
        isr <= '0;
        cvec <= NO_VEC;
        for (int i = 0; i < NQ; i++) begin
          pfn[i] <= '0;
          qvec[i] <= NO_VEC;
        end
      end else begin
        isr <= (rd && at_isr) ? isr_set : (isr | isr_set);
        if (wr) begin
          if (at_gf)  gfeat <= req_wdata[BAD_BIT] ? dev_fallback : req_wdata;
          if (at_pfn) pfn[qsel] <= req_wdata;
          if (at_sel && sel_ok) qsel <= req_wdata[SW-1:0];
          if (at_st)  status <= req_wdata[7:0];
          if (at_cv && msix_en) cvec <= vec_new;
          if (at_qv && msix_en) qvec[qsel] <= vec_new;
        end
      end
    end
  end
endmodule

// File: rtl/pv_regif_chk.sv
module pv_regif_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              msix_en,
  input logic              vec_query_valid,
  input logic              cfg_valid,
  input logic              irq_line,
  input logic              notify_valid,
  input logic              dev_reset
);
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msix_en |-> !irq_line);

  // R5
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |-> !irq_line);

  // R10
  notify_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> $past(req_valid && req_write && req_addr == ADDR_W'(16)));

  // R13
  rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid && !req_write));

  // R12
  cfg_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (req_valid && req_addr >= (msix_en ? ADDR_W'(24) : ADDR_W'(20))));

  // R11
  vq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_query_valid |-> (msix_en && req_write && req_valid));
endmodule

bind pv_regif pv_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .msix_en(msix_en),
  .vec_query_valid(vec_query_valid), .cfg_valid(cfg_valid),
  .irq_line(irq_line), .notify_valid(notify_valid), .dev_reset(dev_reset)
);

// File: tb/pv_regif_bench.sv
module pv_regif_bench;
  localparam int NQ = 16;

  function automatic logic [NQ*16-1:0] mk_sizes();
    logic [NQ*16-1:0] r;
    for (int q = 0; q < NQ; q++) r[q*16 +: 16] = 16'(64 * (q + 1));
    return r;
  endfunction
  localparam logic [NQ*16-1:0] QS = mk_sizes();

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_size = 2;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [7:0] isr_set = 0;
  logic msix_en = 0;
  logic rsp_valid, vec_query_valid, vec_accept, cfg_valid, cfg_write, irq_line;
  logic notify_valid, dev_reset;
  logic [31:0] rsp_rdata, cfg_wdata, cfg_rdata;
  logic [15:0] vec_query_num, notify_queue;
  logic [1:0] cfg_size;
  logic [7:0] cfg_offset;
  logic [31:0] dev_features = 32'h0000_00A5;
  logic [31:0] dev_fallback = 32'h0000_0011;

  assign vec_accept = vec_query_num < 16'd8;
  assign cfg_rdata  = 32'hC0DE_0000 | {24'd0, cfg_offset};

  always #10 clk = ~clk;

  pv_regif #(.NQ(NQ), .ADDR_W(8), .QSIZE_VEC(QS)) u_pv_regif (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dev_features(dev_features),
    .dev_fallback(dev_fallback), .isr_set(isr_set), .msix_en(msix_en),
    .vec_query_valid(vec_query_valid), .vec_query_num(vec_query_num),
    .vec_accept(vec_accept), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
    .cfg_size(cfg_size), .cfg_offset(cfg_offset), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_line(irq_line), .notify_valid(notify_valid),
    .notify_queue(notify_queue), .dev_reset(dev_reset)
  );

  // behavioural model state
  int unsigned m_gf, m_sel, m_st, m_isr, m_cv;
  int unsigned m_pfn [NQ];
  int unsigned m_qv [NQ];
  logic m_rv = 0, m_nv = 0, m_dr = 0;
  logic [31:0] m_rd = 0;
  logic [15:0] m_nq = 0;
  int vectors = 0, misses = 0, cycles = 0;
  string cur_req = "R1";

  task automatic m_clear();
    m_gf = 0; m_sel = 0; m_st = 0; m_isr = 0; m_cv = 16'hFFFF;
    for (int i = 0; i < NQ; i++) begin m_pfn[i] = 0; m_qv[i] = 16'hFFFF; end
  endtask

  function automatic logic [31:0] m_read(int a);
    case (a)
      0: return dev_features | 32'h5100_0000;
      4: return m_gf;
      8: return m_pfn[m_sel];
      12: return {16'd0, QS[m_sel*16 +: 16]};
      14: return m_sel;
      18: return m_st;
      19: return m_isr;
      20: return m_cv;
      22: return m_qv[m_sel];
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear(); m_rv = 0; m_rd = 0; m_nv = 0; m_nq = 0; m_dr = 0;
    end else begin
      int base;
      bit incfg, rst_hit;
      int unsigned nisr;
      base = msix_en ? 24 : 20;
      incfg = req_addr >= base;
      m_rv = req_valid && !req_write;
      if (m_rv) m_rd = incfg ? (32'hC0DE_0000 | 32'(8'(req_addr - base))) : m_read(req_addr);
      m_nv = 0; m_dr = 0; rst_hit = 0;
      nisr = (m_isr | isr_set) & 8'hFF;
      if (req_valid && !req_write && !incfg && req_addr == 19) nisr = isr_set;
      if (req_valid && req_write && !incfg) begin
        case (int'(req_addr))
          4: m_gf = req_wdata[30] ? dev_fallback : req_wdata;
          8: if (req_wdata == 0) rst_hit = 1; else m_pfn[m_sel] = req_wdata;
          14: if (req_wdata[15:0] < NQ) m_sel = req_wdata[15:0];
          16: begin m_nv = 1; m_nq = req_wdata[15:0]; end
          18: begin m_st = req_wdata[7:0]; if (req_wdata[7:0] == 0) rst_hit = 1; end
          20: if (msix_en) m_cv = (req_wdata[15:0] < 8) ? req_wdata[15:0] : 16'hFFFF;
          22: if (msix_en) m_qv[m_sel] = (req_wdata[15:0] < 8) ? req_wdata[15:0] : 16'hFFFF;
          default: ;
        endcase
      end
      if (rst_hit) begin m_clear(); m_dr = 1; nisr = 0; end
      m_isr = nisr;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk); #5;
    if (rst_n) begin
      int base;
      bit mcfg;
      base = msix_en ? 24 : 20;
      mcfg = req_valid && req_addr >= base;
      vectors++;
      chk("R13 rsp_valid", 32'(rsp_valid), 32'(m_rv));
      chk({cur_req, " rsp_rdata"}, rsp_rdata, m_rd);
      chk("R9 irq_line", 32'(irq_line), 32'(!msix_en && m_isr[0]));
      chk("R10 notify_valid", 32'(notify_valid), 32'(m_nv));
      chk("R10 notify_queue", 32'(notify_queue), 32'(m_nq));
      chk("R5 dev_reset", 32'(dev_reset), 32'(m_dr));
      chk("R12 cfg_valid", 32'(cfg_valid), 32'(mcfg));
      if (mcfg) chk("R12 cfg_offset", 32'(cfg_offset), 32'(8'(req_addr - base)));
      chk("R11 vec_query_valid", 32'(vec_query_valid),
          32'(req_valid && req_write && msix_en && (req_addr == 20 || req_addr == 22)));
    end
  end

  task automatic op(input bit w, input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = 8'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    op(0, 4, 0); op(0, 8, 0); op(0, 14, 0); op(0, 18, 0); op(0, 19, 0);
    msix_en = 1; op(0, 20, 0); op(0, 22, 0); msix_en = 0;
    cur_req = "R2";
    op(0, 0, 0);
    cur_req = "R3";
    op(1, 4, 32'h1234_5678); op(0, 4, 0);
    op(1, 4, 32'h4000_0003); op(0, 4, 0);
    cur_req = "R6";
    op(1, 14, 5); op(0, 14, 0); op(1, 14, 16); op(0, 14, 0);
    op(1, 14, 32'h0000_FFFF); op(0, 14, 0); op(1, 14, 15); op(0, 14, 0);
    cur_req = "R4";
    op(1, 14, 5); op(1, 8, 32'h000A_BCDE); op(1, 14, 2); op(1, 8, 32'h111);
    op(0, 8, 0); op(1, 14, 5); op(0, 8, 0);
    cur_req = "R7";
    op(0, 12, 0); op(1, 14, 0); op(0, 12, 0); op(1, 14, 15); op(0, 12, 0);
    cur_req = "R8";
    @(negedge clk); isr_set = 8'h03; @(negedge clk); isr_set = 0; idle(2);
    op(0, 19, 0); op(0, 19, 0);
    @(negedge clk); isr_set = 8'h01; req_valid = 1; req_addr = 19;
    @(negedge clk); isr_set = 0; req_valid = 0;
    idle(1); op(0, 19, 0);
    cur_req = "R9";
    @(negedge clk); isr_set = 8'h01; @(negedge clk); isr_set = 0;
    msix_en = 1; idle(2); msix_en = 0; idle(1); op(0, 19, 0);
    cur_req = "R10";
    op(1, 16, 7); op(1, 16, 32'h0001_0003); idle(1);
    cur_req = "R11";
    msix_en = 1;
    op(1, 20, 3); op(0, 20, 0); op(1, 22, 9); op(0, 22, 0);
    op(1, 22, 5); op(0, 22, 0); op(1, 20, 8); op(0, 20, 0);
    cur_req = "R12";
    op(0, 24, 0); op(0, 27, 0); op(1, 30, 32'hDEAD);
    msix_en = 0;
    op(0, 20, 0); op(0, 23, 0); op(1, 22, 4); op(0, 22, 0);
    cur_req = "R13";
    msix_en = 1; op(0, 21, 0); op(0, 16, 0); op(0, 2, 0); msix_en = 0; op(0, 17, 0);
    cur_req = "R5";
    msix_en = 1;
    op(1, 4, 32'h77); op(1, 18, 32'h107); op(0, 18, 0);
    op(1, 18, 32'h100); op(0, 4, 0); op(0, 18, 0); op(0, 20, 0); op(0, 22, 0); op(0, 14, 0);
    op(1, 14, 3); op(1, 8, 32'h55); op(1, 22, 2); op(1, 14, 6);
    @(negedge clk); isr_set = 8'h01; @(negedge clk); isr_set = 0;
    op(1, 8, 0); op(0, 14, 0); op(1, 14, 3); op(0, 8, 0); op(0, 22, 0); op(0, 19, 0);
    msix_en = 0;
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule